// File: doc/BRIEF.md
# Ramp-Timed Display Supply Sequencer

This block brings up the rails of a display power system in a fixed order. A single counter rises and falls in twelve half-ramps (six rises, six falls). It stands in for the charging and discharging of an external timing capacitor. Each rising half-ramp has a fast segment followed by a slow segment. Every rail turn-on and every gate-drive change is tied to the end of one particular half-ramp. Fault checks are placed at chosen half-ramps.

After the sixth fall, the sequencer reports done. It then watches the rail undervoltage flags and the over-temperature flag continuously. A flag that stays asserted for longer than a timeout trips the fault latch. The latch turns everything off and records which check failed. It holds until enable is dropped or the supply-good flag falls.

A build parameter selects a variant in which the reference and the logic rail follow the supply-good flag alone. In that variant they stay on through a fault latch-off.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: No half-ramp starts and no output leaves its off state while `en_i` or `vdd_ok_i` is low. The sequence starts from half-ramp 0 on the first clock edge at which both are high.
- R2: Even half-ramps (rises) last FAST_CYC+SLOW_CYC cycles and odd half-ramps (falls) last FALL_CYC cycles. `seq_done_o` rises on the edge that ends half-ramp 11, so it is high after 6*(FAST_CYC+SLOW_CYC)+6*FALL_CYC edges.
- R3: `prot_gate_n_o` goes low on the edge that ends half-ramp 2 (the second peak).
- R4: `boost_en_o`, `ss_req_o` and, in the base variant, `logic_en_o` go high on the edge that ends half-ramp 3 (start of the third rise). `ss_req_o` falls when `seq_done_o` rises.
- R5: `neg_en_o` goes high at the end of half-ramp 6 (fourth peak). `dly_gate_n_o` goes low at the end of half-ramp 8 (fifth peak). `pos_en_o` goes high at the end of half-ramp 9 (start of the sixth rise).
- R6: `ref_ok_i` low during half-ramps 0 to 3 latches a fault with `fault_cause_o` = 1.
- R7: `ot_i` high during half-ramp 2 latches a fault with cause 2. `ot_i` is not checked in half-ramps 0 and 1.
- R8: At the end of half-ramp 11, any set bit of `uv_i` latches a fault with cause 3 instead of setting done. The bits of `uv_i` are: bit 0 boost/delayed boost, bit 1 logic, bit 2 negative gate rail, bit 3 positive gate rail.
- R9: While done, an undervoltage or over-temperature flag held for FAULT_TMO consecutive cycles latches a fault on the FAULT_TMO-th edge. The cause is 5 if `ot_i` is high at that edge, otherwise 4. A shorter run of flags has no effect.
- R10: While a fault is latched: all rail enables, `ss_req_o` and `seq_done_o` are low; both gate drives are high; the cause stays fixed whatever `ref_ok_i`, `ot_i` or `uv_i` do.
- R11: `en_i` low or `vdd_ok_i` low clears the latch and the cause (to 0) on the next edge. When both are high again, a full sequence restarts from half-ramp 0.
- R12: In the base variant, `ref_en_o` is high only while `en_i` and `vdd_ok_i` are high with no fault latched. With LOGIC_ALWAYS=1, `ref_en_o` and `logic_en_o` equal `vdd_ok_i`, independent of enable and fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low powers down and releases the fault latch |
| vdd_ok_i | input | 1 | Supply-good flag (supply above start threshold) |
| ref_ok_i | input | 1 | Reference-good flag |
| ot_i | input | 1 | Over-temperature flag |
| uv_i | input | 4 | Rail undervoltage flags: 0 boost, 1 logic, 2 negative, 3 positive |
| prot_gate_n_o | output | 1 | Input-protection switch gate drive, active low |
| dly_gate_n_o | output | 1 | Delayed-boost-output switch gate drive, active low |
| ref_en_o | output | 1 | Reference enable |
| logic_en_o | output | 1 | Logic rail enable |
| boost_en_o | output | 1 | Boost converter enable |
| neg_en_o | output | 1 | Negative gate rail enable |
| pos_en_o | output | 1 | Positive gate rail enable |
| ss_req_o | output | 1 | Soft-start request |
| seq_done_o | output | 1 | Sequence complete |
| fault_cause_o | output | 3 | First fault cause: 0 none, 1 reference, 2 over-temp in ramp, 3 rail at end check, 4 rail in monitor, 5 over-temp in monitor |

## Verification
The hardest case to reach is the continuous monitor. It only runs after a complete 72-cycle bring-up, and its limit sits exactly one cycle beyond a run that must be ignored. The stimulus first completes a clean sequence. It then applies a flag run one cycle short of the timeout and confirms done survives. Finally it applies a full-length run and observes the trip on the exact edge. The ramp-window checks are reached by holding a flag bad from the start, so that the fault edge itself shows which half-ramp performed the check.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int NUM_RAILS  = 4;
  localparam int PHASE_BITS = 4;

  // half-ramp indices whose last cycle triggers an action
  localparam logic [PHASE_BITS-1:0] PH_PROT_END  = 4'd2;
  localparam logic [PHASE_BITS-1:0] PH_BOOST_END = 4'd3;
  localparam logic [PHASE_BITS-1:0] PH_NEG_END   = 4'd6;
  localparam logic [PHASE_BITS-1:0] PH_DLY_END   = 4'd8;
  localparam logic [PHASE_BITS-1:0] PH_POS_END   = 4'd9;
  localparam logic [PHASE_BITS-1:0] PH_LAST      = 4'd11;
  localparam logic [PHASE_BITS-1:0] PH_REF_CHK   = 4'd3;
  localparam logic [PHASE_BITS-1:0] PH_OT_CHK    = 4'd2;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_REF    = 3'd1,
    CAUSE_OT_SEQ = 3'd2,
    CAUSE_UV_END = 3'd3,
    CAUSE_UV_MON = 3'd4,
    CAUSE_OT_MON = 3'd5
  } fault_cause_e;

  // cycles in one half-ramp: rises are fast+slow, falls are fall
  function automatic int unsigned half_ramp_cycles(logic is_fall, int unsigned rise_cyc,
                                                   int unsigned fall_cyc);
    return is_fall ? fall_cyc : rise_cyc;
  endfunction

  // first failing check wins, sequencing checks before monitor checks
  function automatic fault_cause_e pick_cause(logic f_ref, logic f_ot_seq, logic f_uv_end,
                                              logic mon_ot);
    if (f_ref)         return CAUSE_REF;
    else if (f_ot_seq) return CAUSE_OT_SEQ;
    else if (f_uv_end) return CAUSE_UV_END;
    else if (mon_ot)   return CAUSE_OT_MON;
    else               return CAUSE_UV_MON;
  endfunction

endpackage

// File: rtl/pwr_ramp_timer.sv
module pwr_ramp_timer
  import pwr_seq_pkg::*;
#(
  parameter int FAST_CYC = 400,
  parameter int SLOW_CYC = 1600,
  parameter int FALL_CYC = 1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  output logic [PHASE_BITS-1:0] phase_o,
  output logic                  phase_last_o,
  output logic                  fast_seg_o,
  output logic                  seq_end_o
);

  localparam int RISE_CYC = FAST_CYC + SLOW_CYC;
  localparam int MAX_CYC  = (RISE_CYC > FALL_CYC) ? RISE_CYC : FALL_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cur_last;

  assign cur_last     = CW'(half_ramp_cycles(phase_o[0], RISE_CYC, FALL_CYC) - 1);
  assign phase_last_o = run_i && (cnt_q == cur_last);
  assign fast_seg_o   = run_i && !phase_o[0] && (cnt_q < CW'(FAST_CYC));
  assign seq_end_o    = phase_last_o && (phase_o == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_o <= '0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_o <= '0;
    end else if (phase_last_o) begin
      cnt_q <= '0;
      if (phase_o != PH_LAST) phase_o <= phase_o + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwr_fault_mon.sv
module pwr_fault_mon
  import pwr_seq_pkg::*;
#(
  parameter int FAULT_TMO = 5000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm_i,
  input  logic [NUM_RAILS-1:0] uv_i,
  input  logic                 ot_i,
  output logic                 trip_o,
  output logic                 trip_ot_o
);

  localparam int TW = $clog2(FAULT_TMO + 1);

  logic          flag;
  logic [TW-1:0] run_q;

  assign flag      = (|uv_i) | ot_i;
  assign trip_o    = arm_i && flag && (run_q == TW'(FAULT_TMO - 1));
  assign trip_ot_o = ot_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              run_q <= '0;
    else if (!arm_i || !flag)                run_q <= '0;
    else if (run_q != TW'(FAULT_TMO - 1))    run_q <= run_q + 1'b1;
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int FAST_CYC     = 400,
  parameter int SLOW_CYC     = 1600,
  parameter int FALL_CYC     = 1000,
  parameter int FAULT_TMO    = 5000,
  parameter bit LOGIC_ALWAYS = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 vdd_ok_i,
  input  logic                 ref_ok_i,
  input  logic                 ot_i,
  input  logic [NUM_RAILS-1:0] uv_i,
  output logic                 prot_gate_n_o,
  output logic                 dly_gate_n_o,
  output logic                 ref_en_o,
  output logic                 logic_en_o,
  output logic                 boost_en_o,
  output logic                 neg_en_o,
  output logic                 pos_en_o,
  output logic                 ss_req_o,
  output logic                 seq_done_o,
  output logic [2:0]           fault_cause_o
);

  logic supply_on, active, seq_run;
  logic fault_q, done_q;
  fault_cause_e cause_q;
  logic prot_n_q, dly_n_q, boost_q, neg_q, pos_q, ss_q;

  logic [PHASE_BITS-1:0] phase;
  logic phase_last, fast_seg, seq_end;
  logic mon_trip, mon_ot;
  logic f_ref, f_ot_seq, f_uv_end, fault_evt;

  assign supply_on = en_i & vdd_ok_i;
  assign active    = supply_on & ~fault_q;
  assign seq_run   = active & ~done_q;

  pwr_ramp_timer #(
    .FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC), .FALL_CYC(FALL_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(seq_run),
    .phase_o(phase), .phase_last_o(phase_last),
    .fast_seg_o(fast_seg), .seq_end_o(seq_end)
  );

  pwr_fault_mon #(.FAULT_TMO(FAULT_TMO)) u_mon (
    .clk(clk), .rst_n(rst_n), .arm_i(active & done_q),
    .uv_i(uv_i), .ot_i(ot_i),
    .trip_o(mon_trip), .trip_ot_o(mon_ot)
  );

  // checks interleaved with the ramp
  assign f_ref     = seq_run && (phase <= PH_REF_CHK) && !ref_ok_i;
  assign f_ot_seq  = seq_run && (phase == PH_OT_CHK) && ot_i;
  assign f_uv_end  = seq_end && (|uv_i);
  assign fault_evt = f_ref | f_ot_seq | f_uv_end | mon_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0; cause_q <= CAUSE_NONE; done_q <= 1'b0;
      prot_n_q <= 1'b1; dly_n_q <= 1'b1;
      boost_q <= 1'b0; neg_q <= 1'b0; pos_q <= 1'b0; ss_q <= 1'b0;
    end else if (!supply_on || fault_q || fault_evt) begin
      if (!supply_on) begin
        fault_q <= 1'b0;
        cause_q <= CAUSE_NONE;
      end else if (!fault_q) begin
        fault_q <= 1'b1;
        cause_q <= pick_cause(f_ref, f_ot_seq, f_uv_end, mon_ot);
      end
      done_q <= 1'b0;
      prot_n_q <= 1'b1; dly_n_q <= 1'b1;
      boost_q <= 1'b0; neg_q <= 1'b0; pos_q <= 1'b0; ss_q <= 1'b0;
    end else if (phase_last) begin
      unique case (phase)
        PH_PROT_END:  prot_n_q <= 1'b0;
        PH_BOOST_END: begin boost_q <= 1'b1; ss_q <= 1'b1; end
        PH_NEG_END:   neg_q <= 1'b1;
        PH_DLY_END:   dly_n_q <= 1'b0;
        PH_POS_END:   pos_q <= 1'b1;
        PH_LAST:      begin done_q <= 1'b1; ss_q <= 1'b0; end
        default:      ;
      endcase
    end
  end

  generate
    if (LOGIC_ALWAYS) begin : g_supply_tied
      assign ref_en_o   = vdd_ok_i;
      assign logic_en_o = vdd_ok_i;
    end else begin : g_sequenced
      assign ref_en_o   = active;
      assign logic_en_o = boost_q;
    end
  endgenerate

  assign prot_gate_n_o = prot_n_q;
  assign dly_gate_n_o  = dly_n_q;
  assign boost_en_o    = boost_q;
  assign neg_en_o      = neg_q;
  assign pos_en_o      = pos_q;
  assign ss_req_o      = ss_q;
  assign seq_done_o    = done_q;
  assign fault_cause_o = cause_q;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       vdd_ok_i,
  input logic       prot_gate_n_o,
  input logic       dly_gate_n_o,
  input logic       boost_en_o,
  input logic       neg_en_o,
  input logic       pos_en_o,
  input logic       ss_req_o,
  input logic       seq_done_o,
  input logic [2:0] fault_cause_o,
  input logic [3:0] phase,
  input logic       phase_last,
  input logic       fast_seg,
  input logic       mon_trip
);

  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 4'd11);

  p_fast_only_rising_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fast_seg |-> !phase[0]);

  p_done_all_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |-> (pos_en_o && neg_en_o && boost_en_o && !ss_req_o && !dly_gate_n_o));

  p_prot_at_peak2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_gate_n_o) |-> ($past(phase) == 4'd2 && $past(phase_last)));

  p_boost_behind_prot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boost_en_o |-> !prot_gate_n_o);

  p_pos_behind_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_en_o |-> (neg_en_o && !dly_gate_n_o));

  p_mon_trip_latches_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_trip && en_i && vdd_ok_i) |=> (fault_cause_o == 3'd4 || fault_cause_o == 3'd5));

  p_fault_all_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cause_o != 3'd0) |-> (!boost_en_o && !neg_en_o && !pos_en_o && !seq_done_o
                                 && prot_gate_n_o && dly_gate_n_o));

  p_cause_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cause_o != 3'd0 && en_i && vdd_ok_i) |=> $stable(fault_cause_o));

  p_release_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || !vdd_ok_i) |=> (fault_cause_o == 3'd0 && prot_gate_n_o && !boost_en_o));

endmodule

bind pwr_seq_ctrl pwr_seq_chk u_pwr_seq_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .vdd_ok_i(vdd_ok_i),
  .prot_gate_n_o(prot_gate_n_o), .dly_gate_n_o(dly_gate_n_o),
  .boost_en_o(boost_en_o), .neg_en_o(neg_en_o), .pos_en_o(pos_en_o),
  .ss_req_o(ss_req_o), .seq_done_o(seq_done_o), .fault_cause_o(fault_cause_o),
  .phase(phase), .phase_last(phase_last), .fast_seg(fast_seg), .mon_trip(mon_trip)
);

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;

  localparam int FAST = 3, SLOW = 5, FALL = 4, TMO = 6;
  localparam int RISE = FAST + SLOW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, vdd_ok = 1'b0, ref_ok = 1'b1, ot = 1'b0;
  logic [3:0] uv = 4'h0;

  logic prot_n, dly_n, ref_en, logic_en, boost, neg, pos, ss, done;
  logic [2:0] cause;
  logic a_prot_n, a_dly_n, a_ref_en, a_logic_en, a_boost, a_neg, a_pos, a_ss, a_done;
  logic [2:0] a_cause;

  int tests = 0, fails = 0;
  int t_prot, t_boost, t_logic, t_ss_off, t_neg, t_dly, t_pos, t_done, t_cause;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl #(.FAST_CYC(FAST), .SLOW_CYC(SLOW), .FALL_CYC(FALL), .FAULT_TMO(TMO),
                 .LOGIC_ALWAYS(1'b0)) i_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .vdd_ok_i(vdd_ok), .ref_ok_i(ref_ok), .ot_i(ot),
    .uv_i(uv), .prot_gate_n_o(prot_n), .dly_gate_n_o(dly_n), .ref_en_o(ref_en),
    .logic_en_o(logic_en), .boost_en_o(boost), .neg_en_o(neg), .pos_en_o(pos),
    .ss_req_o(ss), .seq_done_o(done), .fault_cause_o(cause));

  pwr_seq_ctrl #(.FAST_CYC(FAST), .SLOW_CYC(SLOW), .FALL_CYC(FALL), .FAULT_TMO(TMO),
                 .LOGIC_ALWAYS(1'b1)) i_pwr_seq_ctrl_alt (
    .clk(clk), .rst_n(rst_n), .en_i(en), .vdd_ok_i(vdd_ok), .ref_ok_i(ref_ok), .ot_i(ot),
    .uv_i(uv), .prot_gate_n_o(a_prot_n), .dly_gate_n_o(a_dly_n), .ref_en_o(a_ref_en),
    .logic_en_o(a_logic_en), .boost_en_o(a_boost), .neg_en_o(a_neg), .pos_en_o(a_pos),
    .ss_req_o(a_ss), .seq_done_o(a_done), .fault_cause_o(a_cause));

  // edges from sequence start until the end of half-ramp ph
  function automatic int edges_through(int ph);
    int total = 0;
    for (int k = 0; k <= ph; k++) total += (k % 2 == 0) ? RISE : FALL;
    return total;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // steps n edges and records the first edge at which each output moved
  task automatic step_watch(int n);
    logic p0, p1, p2, p3, p4, p5, p6, p7;
    logic [2:0] p8;
    p0 = prot_n; p1 = boost; p2 = logic_en; p3 = ss; p4 = neg; p5 = dly_n; p6 = pos;
    p7 = done; p8 = cause;
    t_prot = 0; t_boost = 0; t_logic = 0; t_ss_off = 0; t_neg = 0; t_dly = 0;
    t_pos = 0; t_done = 0; t_cause = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); #1;
      if (t_prot == 0 && prot_n != p0) t_prot = i;
      if (t_boost == 0 && boost != p1) t_boost = i;
      if (t_logic == 0 && logic_en != p2) t_logic = i;
      if (t_ss_off == 0 && p3 && !ss) t_ss_off = i;
      p3 = ss;
      if (t_neg == 0 && neg != p4) t_neg = i;
      if (t_dly == 0 && dly_n != p5) t_dly = i;
      if (t_pos == 0 && pos != p6) t_pos = i;
      if (t_done == 0 && done != p7) t_done = i;
      if (t_cause == 0 && cause != p8) t_cause = i;
    end
  endtask

  task automatic go_idle();
    en = 1'b0; ref_ok = 1'b1; ot = 1'b0; uv = 4'h0; vdd_ok = 1'b1;
    tick(2);
  endtask

  task automatic check_all_off(string req);
    chk(req, "rails off", {boost, neg, pos, ss, done}, 0);
    chk(req, "gates high", {prot_n, dly_n}, 2'b11);
  endtask

  task automatic test_reset_state();
    chk("R1", "reset prot gate", prot_n, 1);
    chk("R1", "reset delay gate", dly_n, 1);
    chk("R1", "reset enables", {ref_en, logic_en, boost, neg, pos, ss, done}, 0);
    chk("R1", "reset cause", cause, 0);
  endtask

  task automatic test_holdoff_then_sequence();
    go_idle();
    step_watch(100);
    chk("R1", "no activity with enable low", t_prot + t_boost + t_done + t_cause, 0);
    chk("R12", "base ref off with enable low", ref_en, 0);
    chk("R12", "variant ref on with supply good", a_ref_en, 1);
    en = 1'b1;
    #0;
    chk("R12", "base ref on when running", ref_en, 1);
    step_watch(edges_through(11) + 4);
    chk("R3", "protection gate edge", t_prot, edges_through(2));
    chk("R4", "boost enable edge", t_boost, edges_through(3));
    chk("R4", "logic enable edge", t_logic, edges_through(3));
    chk("R5", "negative rail edge", t_neg, edges_through(6));
    chk("R5", "delayed gate edge", t_dly, edges_through(8));
    chk("R5", "positive rail edge", t_pos, edges_through(9));
    chk("R2", "done edge", t_done, 6 * RISE + 6 * FALL);
    chk("R4", "soft-start drop edge", t_ss_off, edges_through(11));
    chk("R2", "final state", {done, boost, neg, pos, prot_n, dly_n, cause}, 9'b1111_0000_0);
  endtask

  task automatic test_ref_fault();
    go_idle();
    ref_ok = 1'b0;
    en = 1'b1;
    step_watch(1);
    chk("R6", "reference fault cause", cause, 1);
    ref_ok = 1'b1; ot = 1'b1; uv = 4'hF;
    tick(30);
    chk("R10", "cause held through input changes", cause, 1);
    check_all_off("R10");
    chk("R12", "base ref off in fault", ref_en, 0);
    chk("R12", "variant ref and logic on in fault", {a_ref_en, a_logic_en}, 2'b11);
    ot = 1'b0; uv = 4'h0;
    en = 1'b0;
    tick(1);
    chk("R11", "enable low clears cause", cause, 0);
    en = 1'b1;
    step_watch(edges_through(11) + 2);
    chk("R11", "restart completes", t_done, edges_through(11));
  endtask

  task automatic test_ot_in_ramp();
    go_idle();
    ot = 1'b1;
    en = 1'b1;
    step_watch(edges_through(1) + 4);
    chk("R7", "over-temp fault edge", t_cause, edges_through(1) + 1);
    chk("R7", "over-temp cause", cause, 2);
    chk("R7", "no gate activity before fault", t_prot, 0);
  endtask

  task automatic test_uv_at_end();
    go_idle();
    uv = 4'b0100;
    en = 1'b1;
    step_watch(edges_through(11) + 3);
    chk("R8", "end check fault edge", t_cause, edges_through(11));
    chk("R8", "end check cause", cause, 3);
    chk("R8", "done never set", t_done, 0);
    check_all_off("R8");
  endtask

  task automatic test_monitor();
    go_idle();
    en = 1'b1;
    tick(edges_through(11) + 2);
    chk("R9", "sequence done before monitor", done, 1);
    uv = 4'b0001;
    tick(TMO - 1);
    uv = 4'h0;
    tick(3);
    chk("R9", "short flag run ignored", {done, cause}, 4'b1000);
    uv = 4'b0010;
    step_watch(TMO + 2);
    chk("R9", "undervoltage trip edge", t_cause, TMO);
    chk("R9", "undervoltage monitor cause", cause, 4);
    uv = 4'h0;
    vdd_ok = 1'b0;
    tick(1);
    chk("R11", "supply drop clears cause", cause, 0);
    chk("R12", "variant ref off with supply low", a_ref_en, 0);
    vdd_ok = 1'b1;
    tick(edges_through(11) + 2);
    chk("R11", "supply return restarts", done, 1);
    ot = 1'b1; uv = 4'b1000;
    step_watch(TMO + 1);
    chk("R9", "over-temp trip edge", t_cause, TMO);
    chk("R9", "over-temp monitor cause", cause, 5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    test_reset_state();
    test_holdoff_then_sequence();
    test_ref_fault();
    test_ot_in_ramp();
    test_uv_at_end();
    test_monitor();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule